// File: doc/BRIEF.md
# Pointer-Indexed Card RAM Window

This block gives a host access to a byte-addressed on-card RAM through a narrow register port instead of a memory-mapped aperture. The host loads a write pointer or a read pointer with an offset. It then moves data through one data port. Each data-port access is either a byte or a 16-bit word, and it moves the matching pointer forward by the number of bytes it transferred. Because the two pointers are independent, a host can stream data out of one region while it fills another.

The RAM is organised as up to `BANKS_MAX` banks of `BANK_BYTES` each, and only the lowest `FITTED_BANKS` of them are populated. Writes to an unpopulated bank are lost, and reads from one float high. A host can therefore size the fitted memory by writing a test pattern bank by bank and reading it back, working downward from the top. Word data is little-endian. A word access may start at any byte offset, including an odd one and the very last byte, where it wraps to offset zero. Read data is registered: it appears one cycle after the request, qualified by a valid strobe.

Top module: `ptrwin_top`

## Requirements
- R1: After reset both pointers are zero, `host_rvalid` is low and `host_rdata` is zero.
- R2: A write with `host_sel`=1 loads the write pointer and `host_sel`=2 loads the read pointer from the low `PTR_W` bits of `host_wdata`; higher bits are dropped. A read with the same select returns that pointer zero-extended.
- R3: A data-port write (`host_sel`=0) with `host_word`=1 stores `host_wdata[7:0]` at the write pointer and `host_wdata[15:8]` at the next byte, then adds 2 to the write pointer. With `host_word`=0 it stores only `host_wdata[7:0]` and adds 1.
- R4: A data-port word read returns `{byte[rptr+1], byte[rptr]}` and adds 2 to the read pointer. A byte read returns `{8'h00, byte[rptr]}` and adds 1.
- R5: Byte and word accesses may be mixed on the data port at any alignment, including a word that starts at an odd offset.
- R6: Pointers wrap modulo 2^`PTR_W`. A word access at the last byte uses offset 0 for its upper byte, and it leaves the pointer at 1.
- R7: A data-port read issued in the cycle right after a read-pointer load returns data from the newly loaded offset.
- R8: Data-port writes never move the read pointer, and data-port reads never move the write pointer.
- R9: Bytes in an unpopulated bank ignore writes and read as 8'hFF. A pattern of words starting at 1 and rising by 3 reads back intact only in populated banks.
- R10: `host_rvalid` is high exactly in the cycle after a read request. An access with `host_sel`=3 changes no pointer and no RAM byte, and if it is a read it returns zero.
- R11: A 24-bit value written as two consecutive data-port words, low half first, occupies four consecutive bytes starting at the write pointer, with the top byte zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Access request this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 2 | 0 data port, 1 write pointer, 2 read pointer, 3 unused |
| host_word | input | 1 | Data-port width: 1 = 16 bits, 0 = 8 bits |
| host_wdata | input | 16 | Write data or pointer value |
| host_rdata | output | 16 | Read data, registered |
| host_rvalid | output | 1 | High in the cycle after a read request |

## Verification
The bench builds the block with 64-byte banks, four bank slots and three of them fitted. This gives an 8-bit pointer, so a 16-bit pointer load visibly loses its upper byte. Wrap-around at offset 0xFF is reachable in a few accesses. The top bank is absent, so the downward sizing walk meets one missing bank before it reaches three good ones. Because the missing bank sits at the top of the space, the wrap test also shows that a write to the absent last byte is lost, while the wrapped upper byte reaches offset 0.

// File: rtl/ptrwin_pkg.sv
package ptrwin_pkg;

    localparam int HOST_DW = 16;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_WPTR = 2'd1,
        SEL_RPTR = 2'd2,
        SEL_NONE = 2'd3
    } port_sel_e;

endpackage

// File: rtl/ptrwin_ptr_next.sv
module ptrwin_ptr_next #(
    parameter int PTR_W = 8
) (
    input  logic [PTR_W-1:0] cur,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             step,
    input  logic             step_word,
    output logic [PTR_W-1:0] nxt
);
    localparam logic [PTR_W-1:0] STEP_BYTE = PTR_W'(1);
    localparam logic [PTR_W-1:0] STEP_WORD = PTR_W'(2);

    always_comb begin
        nxt = cur;
        if (load) begin
            nxt = load_val;
        end else if (step) begin
            nxt = cur + (step_word ? STEP_WORD : STEP_BYTE);
        end
    end
endmodule

// File: rtl/ptrwin_ram.sv
module ptrwin_ram #(
    parameter int BANK_BYTES   = 256,
    parameter int BANKS_MAX    = 4,
    parameter int FITTED_BANKS = 3,
    localparam int PTR_W       = $clog2(BANK_BYTES * BANKS_MAX),
    localparam int OFF_W       = $clog2(BANK_BYTES),
    localparam int BSEL_W      = PTR_W - OFF_W
) (
    input  logic             clk,
    input  logic             lo_we,
    input  logic             hi_we,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [15:0]      wdata,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [7:0]       rd_lo,
    output logic [7:0]       rd_hi
);
    logic [PTR_W-1:0] wr_addr_up;
    logic [PTR_W-1:0] rd_addr_up;

    assign wr_addr_up = wr_addr + PTR_W'(1);
    assign rd_addr_up = rd_addr + PTR_W'(1);

    logic [BSEL_W-1:0] wb_lo, wb_hi, rb_lo, rb_hi;
    logic [OFF_W-1:0]  wo_lo, wo_hi, ro_lo, ro_hi;

    assign {wb_lo, wo_lo} = wr_addr;
    assign {wb_hi, wo_hi} = wr_addr_up;
    assign {rb_lo, ro_lo} = rd_addr;
    assign {rb_hi, ro_hi} = rd_addr_up;

    logic [7:0] bank_lo [BANKS_MAX];
    logic [7:0] bank_hi [BANKS_MAX];

    for (genvar b = 0; b < BANKS_MAX; b++) begin : g_bank
        if (b < FITTED_BANKS) begin : g_fitted
            logic [7:0] cells [BANK_BYTES];
            always_ff @(posedge clk) begin
                if (lo_we && (wb_lo == BSEL_W'(b))) begin
                    cells[wo_lo] <= wdata[7:0];
                end
                if (hi_we && (wb_hi == BSEL_W'(b))) begin
                    cells[wo_hi] <= wdata[15:8];
                end
            end
            assign bank_lo[b] = cells[ro_lo];
            assign bank_hi[b] = cells[ro_hi];
        end else begin : g_absent
            assign bank_lo[b] = 8'hFF;
            assign bank_hi[b] = 8'hFF;
        end
    end

    assign rd_lo = bank_lo[rb_lo];
    assign rd_hi = bank_hi[rb_hi];
endmodule

// File: rtl/ptrwin_rdfmt.sv
module ptrwin_rdfmt
    import ptrwin_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  port_sel_e        sel,
    input  logic             word,
    input  logic [7:0]       ram_lo,
    input  logic [7:0]       ram_hi,
    input  logic [PTR_W-1:0] wptr,
    input  logic [PTR_W-1:0] rptr,
    output logic [15:0]      rdata
);
    always_comb begin
        unique case (sel)
            SEL_DATA: rdata = word ? {ram_hi, ram_lo} : {8'h00, ram_lo};
            SEL_WPTR: rdata = 16'(wptr);
            SEL_RPTR: rdata = 16'(rptr);
            default:  rdata = 16'h0000;
        endcase
    end
endmodule

// File: rtl/ptrwin_top.sv
module ptrwin_top
    import ptrwin_pkg::*;
#(
    parameter int BANK_BYTES   = 256,
    parameter int BANKS_MAX    = 4,
    parameter int FITTED_BANKS = 3,
    localparam int PTR_W       = $clog2(BANK_BYTES * BANKS_MAX)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_valid,
    input  logic        host_we,
    input  logic [1:0]  host_sel,
    input  logic        host_word,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        host_rvalid
);
    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [15:0]      rdata;
        logic             rvalid;
    } win_state_t;

    win_state_t state_d, state_q;

    port_sel_e sel;
    logic      data_wr, data_rd, wptr_ld, rptr_ld, any_rd;

    assign sel     = port_sel_e'(host_sel);
    assign data_wr = host_valid &&  host_we && (sel == SEL_DATA);
    assign data_rd = host_valid && !host_we && (sel == SEL_DATA);
    assign wptr_ld = host_valid &&  host_we && (sel == SEL_WPTR);
    assign rptr_ld = host_valid &&  host_we && (sel == SEL_RPTR);
    assign any_rd  = host_valid && !host_we;

    logic [PTR_W-1:0] wptr_nxt, rptr_nxt;
    logic [7:0]       ram_lo, ram_hi;
    logic [15:0]      rd_fmt;

    ptrwin_ptr_next #(.PTR_W(PTR_W)) u_wptr (
        .cur       (state_q.wptr),
        .load      (wptr_ld),
        .load_val  (host_wdata[PTR_W-1:0]),
        .step      (data_wr),
        .step_word (host_word),
        .nxt       (wptr_nxt)
    );

    ptrwin_ptr_next #(.PTR_W(PTR_W)) u_rptr (
        .cur       (state_q.rptr),
        .load      (rptr_ld),
        .load_val  (host_wdata[PTR_W-1:0]),
        .step      (data_rd),
        .step_word (host_word),
        .nxt       (rptr_nxt)
    );

    ptrwin_ram #(
        .BANK_BYTES   (BANK_BYTES),
        .BANKS_MAX    (BANKS_MAX),
        .FITTED_BANKS (FITTED_BANKS)
    ) u_ram (
        .clk     (clk),
        .lo_we   (data_wr),
        .hi_we   (data_wr && host_word),
        .wr_addr (state_q.wptr),
        .wdata   (host_wdata),
        .rd_addr (state_q.rptr),
        .rd_lo   (ram_lo),
        .rd_hi   (ram_hi)
    );

    ptrwin_rdfmt #(.PTR_W(PTR_W)) u_fmt (
        .sel    (sel),
        .word   (host_word),
        .ram_lo (ram_lo),
        .ram_hi (ram_hi),
        .wptr   (state_q.wptr),
        .rptr   (state_q.rptr),
        .rdata  (rd_fmt)
    );

    always_comb begin
        state_d        = state_q;
        state_d.wptr   = wptr_nxt;
        state_d.rptr   = rptr_nxt;
        state_d.rvalid = any_rd;
        if (any_rd) begin
            state_d.rdata = rd_fmt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    logic [PTR_W-1:0] wptr_cur, rptr_cur;
    assign wptr_cur    = state_q.wptr;
    assign rptr_cur    = state_q.rptr;
    assign host_rdata  = state_q.rdata;
    assign host_rvalid = state_q.rvalid;
endmodule

// File: rtl/ptrwin_chk.sv
module ptrwin_chk #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_valid,
    input logic             host_we,
    input logic [1:0]       host_sel,
    input logic             host_word,
    input logic [15:0]      host_wdata,
    input logic             host_rvalid,
    input logic [PTR_W-1:0] wptr,
    input logic [PTR_W-1:0] rptr
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);
    localparam logic [PTR_W-1:0] TWO = PTR_W'(2);

    logic dwr, drd;
    assign dwr = host_valid &&  host_we && (host_sel == 2'd0);
    assign drd = host_valid && !host_we && (host_sel == 2'd0);

    assert_wptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_we && host_sel == 2'd1) |=> (wptr == $past(host_wdata[PTR_W-1:0])));

    assert_rptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_we && host_sel == 2'd2) |=> (rptr == $past(host_wdata[PTR_W-1:0])));

    assert_wptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dwr |=> ((wptr - $past(wptr)) == ($past(host_word) ? TWO : ONE)));

    assert_rptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        drd |=> ((rptr - $past(rptr)) == ($past(host_word) ? TWO : ONE)));

    assert_rptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dwr |=> $stable(rptr));

    assert_wptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drd |=> $stable(wptr));

    assert_rvalid_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !host_we) |=> host_rvalid);

    assert_rvalid_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_valid && !host_we) |=> !host_rvalid);

    assert_sel3_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_sel == 2'd3) |=> ($stable(wptr) && $stable(rptr)));
endmodule

bind ptrwin_top ptrwin_chk #(.PTR_W(PTR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_valid  (host_valid),
    .host_we     (host_we),
    .host_sel    (host_sel),
    .host_word   (host_word),
    .host_wdata  (host_wdata),
    .host_rvalid (host_rvalid),
    .wptr        (wptr_cur),
    .rptr        (rptr_cur)
);

// File: tb/ptrwin_top_tb_top.sv
module ptrwin_top_tb_top;
    localparam int BB = 64;
    localparam int BM = 4;
    localparam int BF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic        host_word = 1'b0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        host_rvalid;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ptrwin_top #(.BANK_BYTES(BB), .BANKS_MAX(BM), .FITTED_BANKS(BF)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_we(host_we),
        .host_sel(host_sel), .host_word(host_word), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access, issued at a falling edge; result sampled at the next falling edge.
    task automatic op(input logic we, input logic [1:0] sel, input logic word,
                      input logic [15:0] wd, output logic [15:0] rd, output logic rv);
        host_valid = 1'b1; host_we = we; host_sel = sel; host_word = word; host_wdata = wd;
        @(negedge clk);
        rd = host_rdata; rv = host_rvalid;
    endtask

    task automatic idle();
        host_valid = 1'b0; host_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic word, input logic [15:0] wd);
        logic [15:0] d; logic v;
        op(1'b1, sel, word, wd, d, v);
    endtask

    task automatic rd(input logic [1:0] sel, input logic word, output logic [15:0] d);
        logic v;
        op(1'b0, sel, word, 16'h0, d, v);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1 rvalid", {15'b0, host_rvalid}, 16'h0);
        check("R1 rdata", host_rdata, 16'h0);
        rd(2'd1, 1'b0, d); check("R1 wptr", d, 16'h0);
        rd(2'd2, 1'b0, d); check("R1 rptr", d, 16'h0);
        idle();
    endtask

    task automatic t_ptr_regs();
        logic [15:0] d;
        wr(2'd1, 1'b1, 16'h1234);
        wr(2'd2, 1'b1, 16'hA75A);
        rd(2'd1, 1'b0, d); check("R2 wptr load drops upper bits", d, 16'h0034);
        rd(2'd2, 1'b0, d); check("R2 rptr load drops upper bits", d, 16'h005A);
        idle();
    endtask

    task automatic t_word_byte();
        logic [15:0] d;
        wr(2'd1, 1'b0, 16'h0010);
        wr(2'd0, 1'b1, 16'hBEEF);
        wr(2'd0, 1'b0, 16'h7711);
        rd(2'd1, 1'b0, d); check("R3 wptr advance 2+1", d, 16'h0013);
        wr(2'd2, 1'b0, 16'h0010);
        rd(2'd0, 1'b0, d); check("R4 byte read", d, 16'h00EF);
        rd(2'd0, 1'b1, d); check("R4 word read little-endian", d, 16'h11BE);
        rd(2'd2, 1'b0, d); check("R4 rptr advance 1+2", d, 16'h0013);
        idle();
    endtask

    task automatic t_odd_transfer();
        logic [15:0] d;
        wr(2'd1, 1'b0, 16'h0021);
        wr(2'd0, 1'b0, 16'h00A1);
        wr(2'd0, 1'b1, 16'hB2C3);
        wr(2'd0, 1'b1, 16'hD4E5);
        wr(2'd0, 1'b0, 16'h00F6);
        wr(2'd2, 1'b0, 16'h0021);
        rd(2'd0, 1'b1, d); check("R5 odd word 0", d, 16'hC3A1);
        rd(2'd0, 1'b1, d); check("R5 odd word 1", d, 16'hE5B2);
        rd(2'd0, 1'b1, d); check("R5 odd word 2", d, 16'hF6D4);
        idle();
    endtask

    task automatic t_wrap();
        logic [15:0] d;
        wr(2'd1, 1'b0, 16'h00FF);
        wr(2'd0, 1'b1, 16'h9C5D);
        rd(2'd1, 1'b0, d); check("R6 wptr wraps to 1", d, 16'h0001);
        wr(2'd2, 1'b0, 16'h00FF);
        rd(2'd0, 1'b1, d); check("R6 wrapped word (absent low byte)", d, 16'h9CFF);
        rd(2'd2, 1'b0, d); check("R6 rptr wraps to 1", d, 16'h0001);
        wr(2'd2, 1'b0, 16'h0000);
        rd(2'd0, 1'b0, d); check("R6 upper byte at offset 0", d, 16'h009C);
        idle();
    endtask

    task automatic t_rptr_reload();
        logic [15:0] d;
        wr(2'd1, 1'b0, 16'h0040);
        wr(2'd0, 1'b1, 16'h2211);
        wr(2'd0, 1'b1, 16'h4433);
        wr(2'd2, 1'b0, 16'h0040);
        rd(2'd0, 1'b1, d); check("R7 first read", d, 16'h2211);
        wr(2'd2, 1'b0, 16'h0042);
        rd(2'd0, 1'b1, d); check("R7 read right after reload", d, 16'h4433);
        idle();
    endtask

    task automatic t_indep();
        logic [15:0] d;
        wr(2'd1, 1'b0, 16'h0050);
        wr(2'd2, 1'b0, 16'h0060);
        wr(2'd0, 1'b1, 16'h1111);
        wr(2'd0, 1'b0, 16'h0022);
        rd(2'd2, 1'b0, d); check("R8 rptr untouched by writes", d, 16'h0060);
        rd(2'd0, 1'b1, d);
        rd(2'd0, 1'b0, d);
        rd(2'd1, 1'b0, d); check("R8 wptr untouched by reads", d, 16'h0053);
        idle();
    endtask

    task automatic t_sizing();
        logic [15:0] d;
        for (int b = BM - 1; b >= 0; b--) begin
            logic [15:0] pat;
            int bad;
            wr(2'd1, 1'b0, 16'(b * BB));
            pat = 16'd1;
            for (int i = 0; i < BB / 2; i++) begin
                wr(2'd0, 1'b1, pat);
                pat = pat + 16'd3;
            end
            wr(2'd2, 1'b0, 16'(b * BB));
            pat = 16'd1;
            bad = 0;
            for (int i = 0; i < BB / 2; i++) begin
                rd(2'd0, 1'b1, d);
                if (b < BF) begin
                    if (d != pat) bad++;
                end else begin
                    if (d != 16'hFFFF) bad++;
                end
                pat = pat + 16'd3;
            end
            check("R9 bank pattern / float-high", 16'(bad), 16'h0);
        end
        idle();
    endtask

    task automatic t_sel3();
        logic [15:0] d; logic v;
        wr(2'd1, 1'b0, 16'h0080);
        wr(2'd2, 1'b0, 16'h0080);
        wr(2'd0, 1'b1, 16'h6655);
        op(1'b1, 2'd3, 1'b1, 16'hFFFF, d, v);
        check("R10 no rvalid on write", {15'b0, v}, 16'h0);
        op(1'b0, 2'd3, 1'b1, 16'h0000, d, v);
        check("R10 rvalid on unused read", {15'b0, v}, 16'h1);
        check("R10 unused read returns zero", d, 16'h0000);
        idle();
        check("R10 rvalid drops when idle", {15'b0, host_rvalid}, 16'h0);
        rd(2'd1, 1'b0, d); check("R10 wptr unchanged", d, 16'h0082);
        rd(2'd2, 1'b0, d); check("R10 rptr unchanged", d, 16'h0080);
        rd(2'd0, 1'b1, d); check("R10 RAM unchanged", d, 16'h6655);
        idle();
    endtask

    task automatic t_addr24();
        logic [15:0] d;
        wr(2'd1, 1'b0, 16'h0070);
        wr(2'd0, 1'b1, 16'h3456);
        wr(2'd0, 1'b1, 16'h0012);
        wr(2'd2, 1'b0, 16'h0070);
        rd(2'd0, 1'b0, d); check("R11 byte 0", d, 16'h0056);
        rd(2'd0, 1'b0, d); check("R11 byte 1", d, 16'h0034);
        rd(2'd0, 1'b0, d); check("R11 byte 2", d, 16'h0012);
        rd(2'd0, 1'b0, d); check("R11 byte 3", d, 16'h0000);
        idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ptr_regs();
        t_word_byte();
        t_odd_transfer();
        t_wrap();
        t_rptr_reload();
        t_indep();
        t_sizing();
        t_sel3();
        t_addr24();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule